// File: doc/BRIEF.md
# Converter Supervisory Mode Sequencer

This block chooses which control source may drive the power switches of a switching converter: nobody, the start-up oscillator, or the main digital controller. It does not sense any voltage and does not switch anything. Analog comparators report a few conditions as flags, and the sequencer turns them into enables for the two control sources. It also produces a command that holds the high-side switch on, and an enable for current limiting.

Every asynchronous pin and comparator flag passes through a two-flop synchronizer before the state machine sees it. A change at such an input therefore reaches the outputs on the third rising clock edge. The outputs are decoded from the state.

The states are off, start-up, run, over-temperature hold and bypass. A thermal stop is honoured only while the main controller reports PWM operation. Restart after a thermal stop needs `COOL_CYCLES` consecutive cool cycles. Undervoltage lockout has two stages. Losing the regulation flag drops the block back to start-up, and losing the start-up flag stops everything. The bypass state holds the high-side switch on. Current limiting is off in bypass for up mode and stays on in bypass for down mode.

Top module: `conv_mode_seq`

## Requirements
- R1: While `shdn_i` is high, all four outputs are low from the third clock edge after it rises. This overrides every other input.
- R2: After reset all outputs are low and the sequencer is in the off state.
- R3: With shut-down low and `start_ok_i` high, the sequencer enters start-up. In up mode this sets `start_en_o`=1 while `main_en_o`=0. In down mode `start_en_o` stays 0.
- R4: In start-up, a high `reg_ok_i` moves control to the main controller: `main_en_o`=1, `ilim_en_o`=1 and `start_en_o`=0. `main_en_o` only rises from the start-up state.
- R5: In run, if `reg_ok_i` falls while `start_ok_i` is high, the sequencer returns to start-up.
- R6: If `start_ok_i` falls in any state, all outputs go low.
- R7: In run, `hot_i` high while `pwm_i`=1 stops the converter and all outputs go low. With `pwm_i`=0 a high `hot_i` has no effect.
- R8: The sequencer leaves the thermal hold only after `hot_i` has been low for `COOL_CYCLES` consecutive synchronized cycles. It leaves into start-up, then goes to run. Any high sample of `hot_i` restarts the count.
- R9: In up mode (`dir_down_i`=0), when `vin_cross_i` is high during run, the sequencer sets `hs_force_o`=1, `ilim_en_o`=0, `main_en_o`=0 and `start_en_o`=0.
- R10: In down mode (`dir_down_i`=1), when `vin_cross_i` is high during run, the sequencer sets `hs_force_o`=1 and `ilim_en_o`=1, with `main_en_o`=0.
- R11: A change on a synchronized input reaches the outputs on the third rising edge and not on the second.
- R12: `dir_down_i` low selects up mode and high selects down mode. In run, the priority is regulation loss, then thermal stop, then bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shdn_i | input | 1 | Shut-down request, high stops all switching |
| dir_down_i | input | 1 | Conversion direction: 0 up, 1 down |
| start_ok_i | input | 1 | Output high enough for the start-up oscillator |
| reg_ok_i | input | 1 | Output high enough for normal regulation |
| hot_i | input | 1 | Die over-temperature flag |
| vin_cross_i | input | 1 | Input beyond target: above it in up mode, below it in down mode |
| pwm_i | input | 1 | Main controller reports PWM operation (synchronous) |
| start_en_o | output | 1 | Enable for the start-up oscillator (low-side switch only) |
| main_en_o | output | 1 | Enable for the main digital controller |
| hs_force_o | output | 1 | Hold the high-side switch on |
| ilim_en_o | output | 1 | Current limiting enable |

## Verification
A wrong state shows directly as a wrong combination of the four outputs, because they are decoded from the state without further registers. The error appears on the third edge after the stimulus. The bench drives every combination of the run-state inputs in both directions and compares the result against the priority order. A wrong cool-down count shows as the start-up enable rising one cycle early or late. A wrong synchronizer depth shows as outputs moving on the second edge instead of the third.

// File: rtl/conv_mode_seq.sv
module conv_mode_seq #(
  parameter int COOL_CYCLES = 64,
  localparam int CW = $clog2(COOL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_i,
  input  logic dir_down_i,
  input  logic start_ok_i,
  input  logic reg_ok_i,
  input  logic hot_i,
  input  logic vin_cross_i,
  input  logic pwm_i,
  output logic start_en_o,
  output logic main_en_o,
  output logic hs_force_o,
  output logic ilim_en_o
);

  typedef enum logic [2:0] {S_OFF, S_START, S_RUN, S_HOT, S_BYP} state_t;

  logic [5:0] raw, s1, s2;
  logic shdn_s, dir_s, start_s, reg_s, hot_s, vin_s;
  state_t state, nxt;
  logic [CW-1:0] cnt;
  logic cool_done;

  assign raw = {shdn_i, dir_down_i, start_ok_i, reg_ok_i, hot_i, vin_cross_i};
  assign {shdn_s, dir_s, start_s, reg_s, hot_s, vin_s} = s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  assign cool_done = !hot_s && (cnt == CW'(COOL_CYCLES - 1));

  always_comb begin
    nxt = state;
    if (shdn_s || !start_s) nxt = S_OFF;
    else begin
      case (state)
        S_OFF:   nxt = S_START;
        S_START: if (reg_s) nxt = S_RUN;
        S_RUN: begin
          if (!reg_s)              nxt = S_START;
          else if (hot_s && pwm_i) nxt = S_HOT;
          else if (vin_s)          nxt = S_BYP;
        end
        S_HOT:   if (cool_done) nxt = S_START;
        S_BYP:   if (!reg_s || !vin_s) nxt = S_START;
        default: nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state != S_HOT || hot_s) cnt <= '0;
      else if (!cool_done)         cnt <= cnt + 1'b1;
    end
  end

  assign start_en_o = (state == S_START) && !dir_s;
  assign main_en_o  = (state == S_RUN);
  assign hs_force_o = (state == S_BYP);
  assign ilim_en_o  = (state == S_RUN) || ((state == S_BYP) && dir_s);

  assert_shdn_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_s |=> !start_en_o && !main_en_o && !hs_force_o && !ilim_en_o);

  assert_uvlo_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_s |=> !start_en_o && !main_en_o && !hs_force_o);

  assert_main_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_en_o) |-> $past(state == S_START));

  assert_hot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en_o && reg_s && hot_s && pwm_i) |=> !main_en_o && !hs_force_o);

  assert_hold_while_hot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOT && hot_s) |=> !start_en_o && !main_en_o);

endmodule

// File: tb/conv_mode_seq_tb.sv
module conv_mode_seq_tb;
  localparam int COOL = 5;

  logic clk = 0, rst_n = 0;
  logic shdn = 0, dir = 0, sok = 0, rok = 0, hot = 0, vinx = 0, pwm = 0;
  logic start_en, main_en, hs_force, ilim_en;
  int checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  conv_mode_seq #(.COOL_CYCLES(COOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .shdn_i(shdn), .dir_down_i(dir),
    .start_ok_i(sok), .reg_ok_i(rok), .hot_i(hot), .vin_cross_i(vinx),
    .pwm_i(pwm), .start_en_o(start_en), .main_en_o(main_en),
    .hs_force_o(hs_force), .ilim_en_o(ilim_en));

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
    end
  end

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {start_en, main_en, hs_force, ilim_en};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b (start,main,hs,ilim)", req, act, exp);
    end
  endtask

  task automatic do_reset(logic d);
    @(negedge clk);
    rst_n = 0; shdn = 0; dir = d; sok = 0; rok = 0; hot = 0; vinx = 0; pwm = 0;
    edges(2);
    @(negedge clk);
    rst_n = 1;
    edges(3);
  endtask

  task automatic bring_up(logic d);
    do_reset(d);
    @(negedge clk);
    sok = 1; rok = 1;
    edges(5);
  endtask

  function automatic logic [3:0] exp_from_run(logic d, logic [5:0] c);
    logic s, so, ro, h, p, v;
    {s, so, ro, h, p, v} = c;
    if (s || !so) return 4'b0000;
    if (!ro) return {!d, 3'b000};
    if (h && p) return 4'b0000;
    if (v) return {2'b00, 1'b1, d};
    return 4'b0101;
  endfunction

  initial begin
    do_reset(0);
    chk("R2 reset state", 4'b0000);

    @(negedge clk); sok = 1;
    edges(2);
    chk("R11 no change at second edge", 4'b0000);
    edges(1);
    chk("R3 R11 up-mode start-up at third edge", 4'b1000);
    @(negedge clk); rok = 1;
    edges(3);
    chk("R4 main controller takes over", 4'b0101);
    @(negedge clk); rok = 0;
    edges(3);
    chk("R5 back to start-up", 4'b1000);
    @(negedge clk); sok = 0;
    edges(3);
    chk("R6 start-up flag lost", 4'b0000);

    do_reset(1);
    @(negedge clk); sok = 1;
    edges(3);
    chk("R3 R12 down mode no start oscillator", 4'b0000);
    @(negedge clk); rok = 1;
    edges(3);
    chk("R4 R12 down-mode run", 4'b0101);

    bring_up(0);
    chk("R4 up-mode run before shut-down", 4'b0101);
    @(negedge clk); shdn = 1; vinx = 1;
    edges(3);
    chk("R1 shut-down overrides", 4'b0000);

    bring_up(0);
    @(negedge clk); pwm = 0; hot = 1;
    edges(4);
    chk("R7 hot ignored in PFM", 4'b0101);
    @(negedge clk); pwm = 1;
    edges(2);
    chk("R7 hot stops in PWM", 4'b0000);
    edges(3);
    @(negedge clk); hot = 0;
    edges(3);
    @(negedge clk); hot = 1;
    edges(1);
    @(negedge clk); hot = 0;
    edges(COOL + 1);
    chk("R8 count restarted by hot glitch", 4'b0000);
    edges(1);
    chk("R8 restart into start-up", 4'b1000);
    edges(1);
    chk("R8 then run", 4'b0101);

    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 64; c++) begin
        bring_up(d[0]);
        @(negedge clk);
        {shdn, sok, rok, hot, pwm, vinx} = c[5:0];
        edges(3);
        if (c[5])                 chk("R1 sweep", exp_from_run(d[0], c[5:0]));
        else if (!c[4])           chk("R6 sweep", exp_from_run(d[0], c[5:0]));
        else if (!c[3])           chk("R5 R12 sweep", exp_from_run(d[0], c[5:0]));
        else if (c[2] && c[1])    chk("R7 R12 sweep", exp_from_run(d[0], c[5:0]));
        else if (c[0] && d == 0)  chk("R9 sweep", exp_from_run(d[0], c[5:0]));
        else if (c[0])            chk("R10 sweep", exp_from_run(d[0], c[5:0]));
        else                      chk("R4 sweep hold", exp_from_run(d[0], c[5:0]));
      end
    end

    finish_run();
  end
endmodule